// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a display output from eight limits that are supplied at run time: for each of the horizontal and vertical axes, the active extent, the counter position where sync begins, the position where sync ends, and the total scan length. Because every boundary is an input rather than a constant, any standard video mode can be loaded without rebuilding the design. Sync begin and end are absolute counter positions: the front porch and the sync width are folded into them before they reach the block.

Each clock is one pixel. An enable input starts and stops the raster. While enable is low, both counters rest at zero and every timing output is low. Once enable rises, the scan starts at the origin of a fresh frame. The limits are copied into internal shadow registers only while the raster is idle or on the last pixel of a frame, so a mode change never tears a frame.

The block also produces the following for a pixel-fetch engine:
- a start-of-frame strobe,
- an end-of-active-line strobe,
- the byte length of one frame at four bytes per pixel.

Top module: `rtg_top`

## Requirements
- R1: While running, the horizontal count steps by one each clock from 0 to the horizontal total minus one, then returns to 0.
- R2: The vertical count steps by one only on the clock where the horizontal count wraps, and returns to 0 after the vertical total minus one.
- R3: Data enable is high exactly when running, the horizontal count is below the horizontal active width, and the vertical count is below the vertical active height.
- R4: Horizontal sync is active high. It is asserted while the horizontal count is at or above the sync-begin position and below the sync-end position. A line therefore carries a pulse of (end − begin) clocks.
- R5: Vertical sync follows the same rule on the vertical count. It stays high for whole lines, so each frame carries (end − begin) × horizontal total clocks of vertical sync.
- R6: One clock after enable is seen low, both counts are 0 and sync, data enable and both strobes are low. The first clock after enable is seen high shows the origin (0,0).
- R7: The limits are taken in only while idle or at the final pixel of a frame. A change made in mid-frame has no effect on any output until the next frame starts.
- R8: The start-of-frame strobe is high for the single clock in which both counts are 0 while running.
- R9: The end-of-line strobe is high for the clock in which the horizontal count equals the active width minus one, on lines whose vertical count is below the active height.
- R10: The frame-length output equals active width × active height × 4 of the limits in force. It is 0 after reset and changes only when the limits are taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the raster when high |
| cfg_h_active | input | 12 | Horizontal active width |
| cfg_h_sync_beg | input | 12 | Horizontal count where sync begins |
| cfg_h_sync_end | input | 12 | Horizontal count where sync ends (exclusive) |
| cfg_h_total | input | 12 | Horizontal scan length (≥ 1) |
| cfg_v_active | input | 12 | Vertical active height |
| cfg_v_sync_beg | input | 12 | Vertical count where sync begins |
| cfg_v_sync_end | input | 12 | Vertical count where sync ends (exclusive) |
| cfg_v_total | input | 12 | Vertical scan length (≥ 1) |
| h_count | output | 12 | Horizontal position |
| v_count | output | 12 | Vertical position |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active pixel flag |
| sof | output | 1 | Start-of-frame strobe |
| eol | output | 1 | Last active pixel of an active line |
| frame_bytes | output | 26 | Byte length of one active frame |

## Verification
The bench checks three corner cases.

**Mid-frame mode change.** Limits are rewritten in the middle of a frame. A design that took them in at once would show a shortened line or a sync pulse in the wrong place before the frame ends.

**Enable dropped mid-line.** When enable is re-raised, a design that failed to clear would resume from the old position instead of the origin.

**Pulse measurements.** Sync pulses are measured in two modes with different porches. An off-by-one in the sync-end comparison would lengthen each pulse by a clock, or by a whole line of vertical sync. A frame length taken from stale limits would show up in the 1280 × 720 check.

// File: rtl/rtg_pkg.sv
// Package: shared constants for the raster timing generator.
// Assumes axis 0 is horizontal and axis 1 is vertical throughout.
package rtg_pkg;
    localparam int unsigned RTG_AXES      = 2;
    localparam int unsigned RTG_AXIS_H    = 0;
    localparam int unsigned RTG_AXIS_V    = 1;
    localparam int unsigned RTG_PIX_BYTES = 4;
    localparam int unsigned RTG_CNT_W_DEF = 12;
endpackage

// File: rtl/rtg_cfg_shadow.sv
// Module: shadow copy of the timing limits and the derived frame length.
// Assumes: load is high only while idle or on the last pixel of a frame;
// outputs hold steady otherwise, so a frame always sees one set of limits.
module rtg_cfg_shadow
    import rtg_pkg::*;
#(
    parameter int unsigned CNT_W = RTG_CNT_W_DEF,
    parameter int unsigned FB_W  = 2 * CNT_W + 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [RTG_AXES-1:0][CNT_W-1:0]     in_active,
    input  logic [RTG_AXES-1:0][CNT_W-1:0]     in_sync_beg,
    input  logic [RTG_AXES-1:0][CNT_W-1:0]     in_sync_end,
    input  logic [RTG_AXES-1:0][CNT_W-1:0]     in_total,
    output logic [RTG_AXES-1:0][CNT_W-1:0]     sh_active,
    output logic [RTG_AXES-1:0][CNT_W-1:0]     sh_sync_beg,
    output logic [RTG_AXES-1:0][CNT_W-1:0]     sh_sync_end,
    output logic [RTG_AXES-1:0][CNT_W-1:0]     sh_total,
    output logic [FB_W-1:0]                    frame_bytes
);

    logic [FB_W-1:0] fb_next;

    // Frame length from the incoming limits, four bytes per pixel.
    always_comb begin
        fb_next = FB_W'(in_active[RTG_AXIS_H]) * FB_W'(in_active[RTG_AXIS_V])
                * FB_W'(RTG_PIX_BYTES);
    end

    // Capture the limits and the frame length on a load event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_active   <= '0;
            sh_sync_beg <= '0;
            sh_sync_end <= '0;
            sh_total    <= '0;
            frame_bytes <= '0;
        end else if (load) begin
            sh_active   <= in_active;
            sh_sync_beg <= in_sync_beg;
            sh_sync_end <= in_sync_end;
            sh_total    <= in_total;
            frame_bytes <= fb_next;
        end
    end

    // R7 / R10: outside a load event the shadow copy does not move.
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sh_active) && $stable(sh_sync_beg)
                   && $stable(sh_sync_end) && $stable(sh_total)))
        else $error("a_r7_shadow_hold");
    a_r10_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(frame_bytes))
        else $error("a_r10_bytes_hold");

endmodule

// File: rtl/rtg_axis.sv
// Module: one raster axis - a wrapping position counter plus the active
// and sync window decoders for that axis.
// Assumes total >= 1 and that the limits stay fixed while the count runs.
module rtg_axis #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] active,
    input  logic [CNT_W-1:0] sync_beg,
    input  logic [CNT_W-1:0] sync_end,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             in_active,
    output logic             at_active_end,
    output logic             in_sync
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Decode the window flags from the current position.
    always_comb begin
        last          = (cnt == total - ONE);
        in_active     = (cnt < active);
        at_active_end = (cnt == active - ONE);
        in_sync       = (cnt >= sync_beg) && (cnt < sync_end);
    end

    // Position counter: cleared, stepped, or wrapped at the total.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= last ? '0 : cnt + ONE;
        end
    end

    // R1 / R2: a step moves the count by exactly one.
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !last && !clr) |=> (cnt == $past(cnt) + ONE))
        else $error("a_r1_step");
    // R1 / R2: a step from the last position lands on zero.
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last && !clr) |=> (cnt == '0))
        else $error("a_r1_wrap");
    // R2: without a step the count holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(cnt))
        else $error("a_r2_hold");

endmodule

// File: rtl/rtg_top.sv
// Module: programmable raster timing generator top.
// Each clock is one pixel. Runs while enable is high, rests at the origin
// with all outputs low while it is low. Limits are taken in while idle or
// on the final pixel of a frame. Assumes both totals are at least 1.
module rtg_top
    import rtg_pkg::*;
#(
    parameter int unsigned CNT_W = RTG_CNT_W_DEF,
    localparam int unsigned FB_W = 2 * CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] cfg_h_active,
    input  logic [CNT_W-1:0] cfg_h_sync_beg,
    input  logic [CNT_W-1:0] cfg_h_sync_end,
    input  logic [CNT_W-1:0] cfg_h_total,
    input  logic [CNT_W-1:0] cfg_v_active,
    input  logic [CNT_W-1:0] cfg_v_sync_beg,
    input  logic [CNT_W-1:0] cfg_v_sync_end,
    input  logic [CNT_W-1:0] cfg_v_total,
    output logic [CNT_W-1:0] h_count,
    output logic [CNT_W-1:0] v_count,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             sof,
    output logic             eol,
    output logic [FB_W-1:0]  frame_bytes
);

    logic                           run_q;
    logic                           frame_end;
    logic                           shadow_load;
    logic [RTG_AXES-1:0][CNT_W-1:0] in_active, in_sync_beg, in_sync_end, in_total;
    logic [RTG_AXES-1:0][CNT_W-1:0] sh_active, sh_sync_beg, sh_sync_end, sh_total;
    logic [RTG_AXES-1:0][CNT_W-1:0] ax_cnt;
    logic [RTG_AXES-1:0]            ax_adv, ax_last, ax_active, ax_act_end, ax_sync;

    // Gather the per-axis limits into arrays indexed by axis.
    always_comb begin
        in_active[RTG_AXIS_H]   = cfg_h_active;
        in_sync_beg[RTG_AXIS_H] = cfg_h_sync_beg;
        in_sync_end[RTG_AXIS_H] = cfg_h_sync_end;
        in_total[RTG_AXIS_H]    = cfg_h_total;
        in_active[RTG_AXIS_V]   = cfg_v_active;
        in_sync_beg[RTG_AXIS_V] = cfg_v_sync_beg;
        in_sync_end[RTG_AXIS_V] = cfg_v_sync_end;
        in_total[RTG_AXIS_V]    = cfg_v_total;
    end

    // Run flag: follows enable one clock later, so the origin shows first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= enable;
        end
    end

    // Step rules and frame-boundary detection.
    always_comb begin
        ax_adv[RTG_AXIS_H] = run_q;
        ax_adv[RTG_AXIS_V] = run_q && ax_last[RTG_AXIS_H];
        frame_end          = run_q && ax_last[RTG_AXIS_H] && ax_last[RTG_AXIS_V];
        shadow_load        = !run_q || frame_end;
    end

    rtg_cfg_shadow #(
        .CNT_W (CNT_W),
        .FB_W  (FB_W)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (shadow_load),
        .in_active   (in_active),
        .in_sync_beg (in_sync_beg),
        .in_sync_end (in_sync_end),
        .in_total    (in_total),
        .sh_active   (sh_active),
        .sh_sync_beg (sh_sync_beg),
        .sh_sync_end (sh_sync_end),
        .sh_total    (sh_total),
        .frame_bytes (frame_bytes)
    );

    for (genvar a = 0; a < RTG_AXES; a++) begin : g_axis
        rtg_axis #(
            .CNT_W (CNT_W)
        ) u_axis (
            .clk           (clk),
            .rst_n         (rst_n),
            .clr           (!enable),
            .adv           (ax_adv[a]),
            .active        (sh_active[a]),
            .sync_beg      (sh_sync_beg[a]),
            .sync_end      (sh_sync_end[a]),
            .total         (sh_total[a]),
            .cnt           (ax_cnt[a]),
            .last          (ax_last[a]),
            .in_active     (ax_active[a]),
            .at_active_end (ax_act_end[a]),
            .in_sync       (ax_sync[a])
        );
    end

    // Drive the timing outputs, all gated low while idle.
    always_comb begin
        h_count = ax_cnt[RTG_AXIS_H];
        v_count = ax_cnt[RTG_AXIS_V];
        de      = run_q && ax_active[RTG_AXIS_H] && ax_active[RTG_AXIS_V];
        hsync   = run_q && ax_sync[RTG_AXIS_H];
        vsync   = run_q && ax_sync[RTG_AXIS_V];
        sof     = run_q && (h_count == '0) && (v_count == '0);
        eol     = run_q && ax_act_end[RTG_AXIS_H] && ax_active[RTG_AXIS_V];
    end

    // R6: enable seen low leaves the raster at rest one clock later.
    a_r6_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (h_count == '0 && v_count == '0 && !hsync && !vsync
                     && !de && !sof && !eol))
        else $error("a_r6_idle_rest");
    // R6: the first running clock shows the origin.
    a_r6_origin_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (h_count == '0 && v_count == '0 && sof))
        else $error("a_r6_origin_first");
    // R2: mid-line the vertical count stays put.
    a_r2_v_still: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && enable && !ax_last[RTG_AXIS_H]) |=> $stable(v_count))
        else $error("a_r2_v_still");

endmodule

// File: tb/rtg_top_tb.sv
// Scoreboard bench: a reference process pushes the expected outputs for each
// clock into a queue; a monitor pops them at the falling edge and compares.
module rtg_top_tb;
    localparam int W   = 12;
    localparam int FBW = 2 * W + 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n, enable;
    logic [W-1:0]   c_ha, c_hsb, c_hse, c_ht, c_va, c_vsb, c_vse, c_vt;
    logic [W-1:0]   h_count, v_count;
    logic           hsync, vsync, de, sof, eol;
    logic [FBW-1:0] frame_bytes;

    rtg_top #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_h_active(c_ha), .cfg_h_sync_beg(c_hsb), .cfg_h_sync_end(c_hse),
        .cfg_h_total(c_ht), .cfg_v_active(c_va), .cfg_v_sync_beg(c_vsb),
        .cfg_v_sync_end(c_vse), .cfg_v_total(c_vt),
        .h_count(h_count), .v_count(v_count), .hsync(hsync), .vsync(vsync),
        .de(de), .sof(sof), .eol(eol), .frame_bytes(frame_bytes)
    );

    typedef struct {
        int h; int v; int hs; int vs; int de; int sof; int eol; int fb;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference state built from the requirements.
    int m_run, mh, mv;
    int s_ha, s_hsb, s_hse, s_ht, s_va, s_vsb, s_vse, s_vt, s_fb;

    task automatic check(string tag, int act, int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
        end
    endtask

    task automatic set_mode(int ha, int hsb, int hse, int ht,
                            int va, int vsb, int vse, int vt);
        c_ha = W'(ha); c_hsb = W'(hsb); c_hse = W'(hse); c_ht = W'(ht);
        c_va = W'(va); c_vsb = W'(vsb); c_vse = W'(vse); c_vt = W'(vt);
    endtask

    // Reference model: next state per edge, then push the expected outputs.
    always @(posedge clk) begin : model
        exp_t x;
        int ld, nr, nh, nv;
        if (!rst_n) begin
            m_run = 0; mh = 0; mv = 0;
            s_ha = 0; s_hsb = 0; s_hse = 0; s_ht = 0;
            s_va = 0; s_vsb = 0; s_vse = 0; s_vt = 0; s_fb = 0;
        end else begin
            ld = (!m_run || (mh == s_ht - 1 && mv == s_vt - 1)) ? 1 : 0; // R7
            nr = m_run; nh = mh; nv = mv;
            if (!enable) begin
                nr = 0; nh = 0; nv = 0;                                   // R6
            end else begin
                if (m_run != 0) begin
                    if (mh == s_ht - 1) begin                             // R1
                        nh = 0;
                        nv = (mv == s_vt - 1) ? 0 : mv + 1;               // R2
                    end else begin
                        nh = mh + 1;
                    end
                end
                nr = 1;
            end
            m_run = nr; mh = nh; mv = nv;
            if (ld != 0) begin
                s_ha = int'(c_ha); s_hsb = int'(c_hsb); s_hse = int'(c_hse); s_ht = int'(c_ht);
                s_va = int'(c_va); s_vsb = int'(c_vsb); s_vse = int'(c_vse); s_vt = int'(c_vt);
                s_fb = s_ha * s_va * 4;                                   // R10
            end
        end
        x.h   = mh;
        x.v   = mv;
        x.de  = (m_run != 0 && mh < s_ha && mv < s_va) ? 1 : 0;
        x.hs  = (m_run != 0 && mh >= s_hsb && mh < s_hse) ? 1 : 0;
        x.vs  = (m_run != 0 && mv >= s_vsb && mv < s_vse) ? 1 : 0;
        x.sof = (m_run != 0 && mh == 0 && mv == 0) ? 1 : 0;
        x.eol = (m_run != 0 && mh == s_ha - 1 && mv < s_va) ? 1 : 0;
        x.fb  = s_fb;
        q.push_back(x);
    end

    // Monitor: compare every clock's outputs; also measure sync pulse widths.
    int hs_run = 0, hs_w = 0, vs_run = 0, vs_w = 0;
    always @(negedge clk) begin
        if (q.size() > 0 && !done) begin
            e = q.pop_front();
            check("R1 h_count", int'(h_count), e.h);
            check("R2 v_count", int'(v_count), e.v);
            check("R3 de", int'(de), e.de);
            check("R4 hsync", int'(hsync), e.hs);
            check("R5 vsync", int'(vsync), e.vs);
            check("R8 sof", int'(sof), e.sof);
            check("R9 eol", int'(eol), e.eol);
            check("R10 frame_bytes", int'(frame_bytes), e.fb);
        end
        if (hsync) hs_run++; else if (hs_run > 0) begin hs_w = hs_run; hs_run = 0; end
        if (vsync) vs_run++; else if (vs_run > 0) begin vs_w = vs_run; vs_run = 0; end
    end

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0; enable = 1'b0;
        set_mode(16, 20, 24, 30, 8, 10, 12, 14);      // mode A: 420 clocks/frame
        repeat (3) @(negedge clk);
        check("R6 reset h_count", int'(h_count), 0);
        check("R10 reset frame_bytes", int'(frame_bytes), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle load", int'(frame_bytes), 16 * 8 * 4);
        enable = 1'b1;
        @(negedge clk);
        check("R6 origin after enable", int'(sof), 1);
        repeat (2 * 420 + 100) @(negedge clk);
        hs_w = 0; vs_w = 0;
        repeat (300) @(negedge clk);
        check("R4 mode A hsync width", hs_w, 4);
        check("R5 mode A vsync width", vs_w, 2 * 30);
        // R7: change the mode mid-frame; the current frame must finish unchanged.
        set_mode(20, 22, 27, 32, 10, 11, 13, 15);     // mode B: 480 clocks/frame
        repeat (3 * 480) @(negedge clk);
        hs_w = 0; vs_w = 0;
        repeat (480) @(negedge clk);
        check("R4 mode B hsync width", hs_w, 5);
        check("R5 mode B vsync width", vs_w, 2 * 32);
        check("R10 mode B bytes", int'(frame_bytes), 20 * 10 * 4);
        // R6: drop enable mid-line, then resume from the origin.
        repeat (37) @(negedge clk);
        enable = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 idle hsync", int'(hsync), 0);
        check("R6 idle v_count", int'(v_count), 0);
        enable = 1'b1;
        repeat (600) @(negedge clk);
        // R10: large mode loaded while idle.
        enable = 1'b0;
        set_mode(1280, 1390, 1430, 1650, 720, 725, 730, 750);
        repeat (4) @(negedge clk);
        check("R10 1280x720 bytes", int'(frame_bytes), 1280 * 720 * 4);
        check("R6 idle de", int'(de), 0);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule